// File: doc/BRIEF.md
# Two-Stage SD Card Clock Generator

This block derives the SD card clock from the base clock with two counters in series. The first is a power-of-two prescaler and the second is a linear divider. A single 32-bit control word, reached through a simple write/read port, holds both division codes and three enable bits. The card clock runs only while all three enables are set and the division fields are not all zero. It drives three outputs: a toggling card clock, a one-cycle strobe that marks each rising edge, and an activity flag.

The prescaler code sits in bits 15:8. Its highest set bit k selects division by 2^(k+1), and a code of zero bypasses the prescaler (division by 1). The divider code sits in bits 7:4 and divides by code+1. The total division N is the product of the two. Each output period starts with a low phase of floor(N/2) base cycles, followed by a high phase of the remaining cycles.

A control state machine with three states keeps the output free of short pulses when software reprograms the block:

- ST_OFF: the clock is stopped.
- ST_RUN: the counters are running.
- ST_FINISH: a change arrived during a high phase, so the old setting completes that phase first.

It has six named transitions:

- T_START: ST_OFF to ST_RUN, when the enables are set and the fields are nonzero.
- T_RELOAD: ST_RUN to ST_RUN, when a new setting is loaded during a low phase or on the last cycle of a period. The counters restart from zero.
- T_HALT: ST_RUN to ST_OFF, when the clock stops during a low phase.
- T_DEFER: ST_RUN to ST_FINISH, when a change arrives in mid-high phase.
- T_RESUME: ST_FINISH to ST_RUN, when the high phase ends and a valid setting is present. The new setting is loaded.
- T_DRAIN_STOP: ST_FINISH to ST_OFF, when the high phase ends and the clock is to stop.

Top module: `sdclk_gen`

## Requirements
- R1: A synchronous active-high reset clears the whole control word, drives the card clock, strobe and activity flag low, and leaves the clock stopped.
- R2: A write at byte offset 0x2C stores the data masked with 0x0000_FFF7. A read at that offset returns the stored value, so bits 31:16 and bit 3 read as zero.
- R3: A write to any other offset leaves the control word unchanged. A read at any other offset returns zero.
- R4: With prescaler code 2^k (bits 15:8) and divider code 0, the card clock period is 2^(k+1) base cycles.
- R5: The divider code in bits 7:4 multiplies the period by code+1, from 1 to 16.
- R6: When the total division N is odd, the high phase is ceil(N/2) cycles and the low phase is floor(N/2) cycles. For example, N=3 gives a high phase of 2 and a low phase of 1.
- R7: A prescaler code with several bits set is decoded by its highest set bit. A code of zero divides by 1.
- R8: Bit 0, bit 1 and bit 2 are the three enables. If any one of them is clear, the card clock stays low and the activity flag stays low.
- R9: With all division fields zero, the clock stays stopped even when the enables are set. It starts only once a nonzero setting is written with the enables set.
- R10: When a change arrives during a high phase, that high phase completes at its old length. The new setting then starts with both counters at zero and a full new low phase, so no pulse is shorter than the half-period in force.
- R11: The strobe is high for exactly the first base cycle of each high phase and low at all other times.
- R12: The activity flag is high whenever the card clock is running and low once it has stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control port |
| addr | input | 12 | Byte offset for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| sd_clk | output | 1 | Divided card clock |
| clk_stb | output | 1 | One-cycle pulse on each card clock rising edge |
| clk_active | output | 1 | High while the divided clock is running |

## Verification
The hardest case to reach from the ports is a rewrite that lands in the middle of a high phase. It must push the machine into ST_FINISH, or into the last-cycle reload, instead of an immediate restart. The stimulus waits for a sampled rising edge of the card clock and issues the write one cycle later. It then counts the remaining high cycles, the following low phase and the next high phase, and compares them with the old high length and the new half-periods. Odd divisions, multi-bit prescaler codes, each single enable being cleared and the zero-field word are each driven separately. The measured high and low lengths go through an expectation queue.

// File: rtl/sdcg_pkg.sv
`timescale 1ns/1ps
package sdcg_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } sdcg_state_e;

    // Field placement inside the control word (neighbouring software decodes these)
    localparam int EN_BITS  = 3;
    localparam int DIV_LSB  = 4;

endpackage

// File: rtl/sdcg_csr.sv
`timescale 1ns/1ps
module sdcg_csr #(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] OFFSET = 12'h02C,
    parameter int          PRE_W  = 8,
    parameter int          DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [PRE_W-1:0]  pre_f,
    output logic [DIV_W-1:0]  div_f,
    output logic [2:0]        en_f
);
    import sdcg_pkg::*;

    localparam int PRE_LSB = DIV_LSB + DIV_W;
    localparam logic [31:0] FIELD_MASK =
        ((32'h1 << (PRE_LSB + PRE_W)) - 32'h1) & ~((32'h1 << DIV_LSB) - 32'h1);
    localparam logic [31:0] KEEP_MASK = FIELD_MASK | ((32'h1 << EN_BITS) - 32'h1);

    logic [31:0] csr_q;
    logic        hit;

    assign hit = (addr == ADDR_W'(OFFSET));

    always_ff @(posedge clk) begin
        if (rst)
            csr_q <= '0;
        else if (wr_en && hit)
            csr_q <= wdata & KEEP_MASK;
    end

    assign rdata = hit ? csr_q : 32'h0;
    assign pre_f = csr_q[PRE_LSB +: PRE_W];
    assign div_f = csr_q[DIV_LSB +: DIV_W];
    assign en_f  = csr_q[2:0];

    AST_CSR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (rdata == ($past(wdata) & KEEP_MASK)) || !hit); // R2
    AST_MISS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> $stable(csr_q)); // R3

endmodule

// File: rtl/sdcg_decode.sv
`timescale 1ns/1ps
module sdcg_decode #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4,
    parameter int SH_W  = 4,
    parameter int POS_W = 12
) (
    input  logic [PRE_W-1:0] pre_code,
    input  logic [DIV_W-1:0] div_code,
    output logic [SH_W-1:0]  shift,
    output logic [PRE_W-1:0] pre_max,
    output logic [POS_W:0]   n_total,
    output logic [POS_W-1:0] l_half
);
    logic [PRE_W:0] pre_div;
    logic [PRE_W:0] pre_div_m1;
    logic [POS_W:0] lin_div;

    // Highest set bit wins: ascending scan, later hits overwrite earlier ones
    always_comb begin
        shift = '0;
        for (int i = 0; i < PRE_W; i++)
            if (pre_code[i]) shift = SH_W'(i + 1);
    end

    always_comb begin
        pre_div    = (PRE_W+1)'(1) << shift;
        pre_div_m1 = pre_div - (PRE_W+1)'(1);
        pre_max    = pre_div_m1[PRE_W-1:0];
        lin_div    = (POS_W+1)'(div_code) + (POS_W+1)'(1);
        n_total    = lin_div << shift;
        l_half     = n_total[POS_W:1];
    end

endmodule

// File: rtl/sdcg_counter.sv
`timescale 1ns/1ps
module sdcg_counter #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4,
    parameter int SH_W  = 4,
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [PRE_W-1:0] pre_max,
    input  logic [DIV_W-1:0] div_max,
    input  logic [SH_W-1:0]  shift,
    output logic [POS_W-1:0] pos,
    output logic             at_end
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_wrap;

    assign pre_wrap = (pre_cnt == pre_max);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (adv) begin
            if (pre_wrap) begin
                pre_cnt <= '0;
                div_cnt <= (div_cnt == div_max) ? '0 : div_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assign pos    = (POS_W'(div_cnt) << shift) | POS_W'(pre_cnt);
    assign at_end = pre_wrap && (div_cnt == div_max);

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (pre_cnt <= pre_max)); // R4
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (div_cnt <= div_max)); // R5
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pos == '0)); // R10

endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen #(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] OFFSET = 12'h02C,
    parameter int          PRE_W  = 8,
    parameter int          DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              sd_clk,
    output logic              clk_stb,
    output logic              clk_active
);
    import sdcg_pkg::*;

    localparam int SH_W  = $clog2(PRE_W + 1);
    localparam int POS_W = PRE_W + DIV_W;

    sdcg_state_e      state, state_d;
    logic [PRE_W-1:0] pre_f, act_pre;
    logic [DIV_W-1:0] div_f, act_div;
    logic [2:0]       en_f;
    logic [SH_W-1:0]  shift;
    logic [PRE_W-1:0] pre_max;
    logic [POS_W:0]   n_total;
    logic [POS_W-1:0] l_half;
    logic [POS_W-1:0] pos;
    logic             at_end;
    logic             go, cfg_chg, evt, load, clr, adv;
    logic             running, hi_phase;
    logic             sd_clk_q, stb_q, act_q;

    sdcg_csr #(.ADDR_W(ADDR_W), .OFFSET(OFFSET), .PRE_W(PRE_W), .DIV_W(DIV_W)) u_csr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pre_f(pre_f), .div_f(div_f), .en_f(en_f)
    );

    sdcg_decode #(.PRE_W(PRE_W), .DIV_W(DIV_W), .SH_W(SH_W), .POS_W(POS_W)) u_dec (
        .pre_code(act_pre), .div_code(act_div), .shift(shift),
        .pre_max(pre_max), .n_total(n_total), .l_half(l_half)
    );

    sdcg_counter #(.PRE_W(PRE_W), .DIV_W(DIV_W), .SH_W(SH_W), .POS_W(POS_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .adv(adv), .pre_max(pre_max),
        .div_max(act_div), .shift(shift), .pos(pos), .at_end(at_end)
    );

    assign go       = (&en_f) && ({pre_f, div_f} != '0);
    assign cfg_chg  = ({pre_f, div_f} != {act_pre, act_div});
    assign evt      = !go || cfg_chg;
    assign running  = (state != ST_OFF);
    assign hi_phase = (pos >= l_half);

    // Next state and transition selection
    always_comb begin
        state_d = state;
        load    = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (go) begin                         // T_START
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (evt) begin
                    if (!hi_phase || at_end) begin
                        if (go) load = 1'b1;          // T_RELOAD
                        else    state_d = ST_OFF;     // T_HALT
                    end else begin
                        state_d = ST_FINISH;          // T_DEFER
                    end
                end
            end
            ST_FINISH: begin
                if (at_end) begin
                    if (go) begin                     // T_RESUME
                        state_d = ST_RUN;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_OFF;             // T_DRAIN_STOP
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign clr = load || (state_d == ST_OFF);
    assign adv = !clr;

    // State register and active setting
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            act_pre <= '0;
            act_div <= '0;
        end else begin
            state <= state_d;
            if (load) begin
                act_pre <= pre_f;
                act_div <= div_f;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sd_clk_q <= 1'b0;
            stb_q    <= 1'b0;
            act_q    <= 1'b0;
        end else begin
            sd_clk_q <= running && hi_phase;
            stb_q    <= running && (pos == l_half);
            act_q    <= running;
        end
    end

    assign sd_clk     = sd_clk_q;
    assign clk_stb    = stb_q;
    assign clk_active = act_q;

    AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_clk_q) |-> stb_q); // R11
    AST_ACTIVE_COVERS_CLK: assert property (@(posedge clk) disable iff (rst)
        sd_clk_q |-> act_q); // R12
    AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
        (!act_q && !(&en_f)) |=> !sd_clk_q); // R8
    AST_ZERO_CFG_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && {pre_f, div_f} == '0) |=> !act_q); // R9

endmodule

// File: tb/sdclk_gen_test.sv
`timescale 1ns/1ps
module sdclk_gen_test;

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = 12'h02C;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        sd_clk, clk_stb, clk_active;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    sdclk_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sd_clk(sd_clk), .clk_stb(clk_stb), .clk_active(clk_active)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg(input logic [7:0] p, input logic [3:0] d);
        return {16'h0, p, d, 4'h7};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 12'h02C;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata == e, tag, rdata, e);
        addr = 12'h02C;
    endtask

    task automatic push(input int hi, input int lo, input string tag);
        exp_t e;
        e.hi = hi; e.lo = lo; e.tag = tag;
        exp_q.push_back(e);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: measures one full card-clock period per queued expectation
    bit   m_p, m_stb_ok;
    int   m_hi, m_lo;
    exp_t m_e;
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                m_e = exp_q[0];
                m_p = sd_clk;
                forever begin
                    @(negedge clk);
                    if (!m_p && sd_clk) break;
                    m_p = sd_clk;
                end
                m_hi = 0; m_lo = 0; m_stb_ok = 1'b1;
                while (sd_clk) begin
                    if (clk_stb != (m_hi == 0)) m_stb_ok = 1'b0;
                    m_hi++;
                    @(negedge clk);
                end
                while (!sd_clk) begin
                    if (clk_stb) m_stb_ok = 1'b0;
                    m_lo++;
                    @(negedge clk);
                end
                chk(m_hi == m_e.hi, {m_e.tag, " high phase"}, m_hi, m_e.hi);
                chk(m_lo == m_e.lo, {m_e.tag, " low phase"}, m_lo, m_e.lo);
                chk(m_stb_ok, "R11 strobe on first high cycle only", m_stb_ok, 1);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    int hi, lo, hi2;
    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        // R1: reset state
        rd_chk(12'h02C, 32'h0, "R1 control word after reset");
        chk(sd_clk == 1'b0, "R1 sd_clk after reset", sd_clk, 0);
        chk(clk_active == 1'b0, "R1 clk_active after reset", clk_active, 0);

        // R2 / R3: register access
        wr(12'h02C, 32'hFFFF_FFFF);
        rd_chk(12'h02C, 32'h0000_FFF7, "R2 readback masks unused bits");
        rd_chk(12'h030, 32'h0, "R3 read at other offset");
        wr(12'h028, 32'h0001_2345);
        rd_chk(12'h02C, 32'h0000_FFF7, "R3 write at other offset ignored");
        idle(2);
        chk(clk_active == 1'b1, "R12 active with valid setting", clk_active, 1);

        // R4: prescaler alone
        wr(12'h02C, cfg(8'h04, 4'd0)); idle(9000);
        push(4, 4, "R4 prescale code 0x04");
        wr(12'h02C, cfg(8'h80, 4'd0)); idle(20);
        push(128, 128, "R4 prescale code 0x80");

        // R5: linear divider
        wr(12'h02C, cfg(8'h01, 4'd4)); idle(300);
        push(5, 5, "R5 divider code 4");
        wr(12'h02C, cfg(8'h01, 4'd15)); idle(30);
        push(16, 16, "R5 divider code 15");

        // R6: odd totals
        wr(12'h02C, cfg(8'h00, 4'd2)); idle(40);
        push(2, 1, "R6 total 3");
        wr(12'h02C, cfg(8'h00, 4'd6)); idle(10);
        push(4, 3, "R6 total 7");

        // R7: non-power-of-two prescaler codes
        wr(12'h02C, cfg(8'h06, 4'd1)); idle(10);
        push(8, 8, "R7 code 0x06 as 0x04");
        wr(12'h02C, cfg(8'h03, 4'd0)); idle(20);
        push(2, 2, "R7 code 0x03 as 0x02");

        // R10: rewrite during a high phase
        wr(12'h02C, cfg(8'h01, 4'd3)); idle(20);
        m_p = sd_clk;
        forever begin
            @(negedge clk);
            if (!m_p && sd_clk) break;
            m_p = sd_clk;
        end
        hi = 1;
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h02C; wdata = cfg(8'h01, 4'd1);
        if (sd_clk) hi++;
        @(negedge clk);
        wr_en = 1'b0;
        while (sd_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!sd_clk) begin lo++; @(negedge clk); end
        hi2 = 0;
        while (sd_clk) begin hi2++; @(negedge clk); end
        chk(hi == 4, "R10 interrupted high phase keeps old length", hi, 4);
        chk(lo == 2, "R10 first low phase uses new half period", lo, 2);
        chk(hi2 == 2, "R10 first new high phase", hi2, 2);

        // R8: each enable alone stops the clock
        for (int k = 0; k < 3; k++) begin
            wr(12'h02C, cfg(8'h01, 4'd1) & ~(32'h1 << k));
            idle(8);
            for (int s = 0; s < 6; s++) begin
                @(negedge clk);
                chk(sd_clk == 1'b0, "R8 clock low with one enable clear", sd_clk, 0);
            end
            chk(clk_active == 1'b0, "R12 inactive with enable clear", clk_active, 0);
            wr(12'h02C, cfg(8'h01, 4'd1)); idle(4);
            push(2, 2, "R8 restart after enables restored");
        end

        // R9: zero fields keep clock stopped
        wr(12'h02C, 32'h0000_0007); idle(8);
        for (int s = 0; s < 10; s++) begin
            @(negedge clk);
            chk(sd_clk == 1'b0 && clk_active == 1'b0, "R9 stopped with zero fields",
                {sd_clk, clk_active}, 0);
        end
        wr(12'h02C, cfg(8'h01, 4'd1)); idle(2);
        chk(clk_active == 1'b1, "R9 restarts on nonzero setting", clk_active, 1);
        push(2, 2, "R9 period after restart");

        // R1: synchronous reset while running
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0;
        idle(1);
        rd_chk(12'h02C, 32'h0, "R1 control word after mid-run reset");
        chk(sd_clk == 1'b0 && clk_active == 1'b0, "R1 stopped after mid-run reset",
            {sd_clk, clk_active}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule